// File: doc/BRIEF.md
# Clock Startup Reset Sequencer

This block orders the reset release of a clock-generation unit, which has to leave reset before anything else on the chip. It has two active-low reset inputs, one for the PLL and one for the rest of the clock logic. It also takes a PLL-lock indication, an alignment pulse and two strap inputs: test mode and divider bypass. All of them are sampled in the fast core clock domain. Both resets may assert asynchronously. Every reset the block produces is released synchronously, through a chain of synchronizer flops.

Once the global logic reset is released, the sequencer waits for PLL lock and then for the first alignment pulse. One cycle after that pulse it releases an aligned reset. From then on it produces two one-cycle clock enables:
- a half-rate enable, with its first pulse 2 cycles after the aligned release;
- a quarter-rate enable, with its first pulse 4 cycles after the aligned release.

After the first quarter-rate pulse has been produced, it raises a ready flag. A chip-level reset controller waits for this flag before releasing the other blocks.

The block also holds one configuration word. A cold reset (the PLL reset) returns the whole word to its defaults. A warm reset (the logic reset alone) keeps the clock-programming byte and restores the rest.

Top module: `clkgen_rst_seq`

## Requirements
- R1: `pll_rst_out_n` goes low as soon as `pll_rst_n` goes low. It goes high at the second rising clock edge at which `pll_rst_n` is sampled high.
- R2: `gclk_rst_n` is never high while `pll_rst_out_n` is low. A logic reset released before the PLL reset has no effect until the PLL reset output has gone high.
- R3: `gclk_rst_n` goes high at the second rising edge at which both `logic_rst_n` and `pll_rst_out_n` are sampled high. It goes low at once when either reset input goes low.
- R4: `aligned_rst_n` goes high in the cycle after the first edge at which `align_pulse` is sampled high, counting only edges after `pll_lock` has been seen. Alignment pulses before lock are ignored.
- R5: `io2x_en` is a one-cycle pulse every 2 cycles. Its first pulse is 2 cycles after `aligned_rst_n` rises, and it is low whenever `aligned_rst_n` is low.
- R6: `io_en` is a one-cycle pulse every 4 cycles. Its first pulse is 4 cycles after `aligned_rst_n` rises, and every `io_en` pulse coincides with an `io2x_en` pulse.
- R7: `ready` goes high in the cycle after the first `io_en` pulse, provided `pll_lock` is high and both straps are low. It is never high while `aligned_rst_n` is low.
- R8: While `test_mode` or `div_bypass` is sampled high, `ready` is low in the following cycle.
- R9: On a cold reset, `cfg_q` takes the default 0x5A3C. On a warm reset, bits [7:0] are kept and bits [15:8] return to the default 0x5A. In the kept byte, bits [3:0] hold the PLL multiplier and bits [7:4] the divider select.
- R10: A write (`cfg_we` high at a rising edge) loads `cfg_wdata` into `cfg_q` only if `gclk_rst_n` is high. Writes made while it is low are ignored.
- R11: Asserting either reset input drops `ready`, `aligned_rst_n` and both enables at once. After release, the whole sequence runs again, starting with the wait for lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pll_rst_n | input | 1 | Asynchronous active-low PLL (cold) reset |
| logic_rst_n | input | 1 | Asynchronous active-low logic (warm) reset |
| pll_lock | input | 1 | PLL locked indication |
| align_pulse | input | 1 | Clock alignment event |
| test_mode | input | 1 | Test strap, must be low for functional use |
| div_bypass | input | 1 | Divider bypass strap, must be low for functional use |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| pll_rst_out_n | output | 1 | Synchronously released PLL reset |
| gclk_rst_n | output | 1 | Synchronously released global logic reset |
| aligned_rst_n | output | 1 | Aligned reset for internal blocks |
| io2x_en | output | 1 | Half-rate clock enable |
| io_en | output | 1 | Quarter-rate clock enable |
| ready | output | 1 | Clocks stable, chip reset may be released |
| cfg_q | output | 16 | Configuration word |

## Verification
The following are checked by assertions on every cycle:
- the ordering of the PLL reset and the global reset;
- that the aligned release follows an alignment pulse;
- the single-cycle shape of both enables and the coincidence of the quarter-rate pulse with a half-rate pulse;
- that `ready` implies the aligned reset is released and that it drops after either strap is seen high.

The remaining behaviour can only be shown by the bench's scenarios, with its reference model compared on every clock:
- the exact synchronizer latencies and the enable offsets after alignment;
- that early alignment pulses are ignored;
- the split of the configuration word under warm and cold reset, and writes dropped during reset;
- the full restart of the sequence after a reset.

// File: rtl/clkgen_rst_seq_pkg.sv
package clkgen_rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_SPIN  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkgen_en_gen.sv
module clkgen_en_gen #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aligned,
  output logic fast_en,
  output logic slow_en
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fast_q, fast_d;
  logic          slow_q, slow_d;
  logic          fast_hit, slow_hit;

  // cnt_q equals cycles since aligned release, modulo SLOW_DIV
  assign fast_hit = ((32'(cnt_q) % FAST_DIV) == (FAST_DIV - 1));
  assign slow_hit = (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    fast_d = 1'b0;
    slow_d = 1'b0;
    if (!aligned) begin
      cnt_d = '0;
    end else begin
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      fast_d = fast_hit;
      slow_d = slow_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fast_q <= fast_d;
      slow_q <= slow_d;
    end
  end

  assign fast_en = fast_q;
  assign slow_en = slow_q;
endmodule

// File: rtl/clkgen_seq_fsm.sv
module clkgen_seq_fsm
  import clkgen_rst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pll_lock,
  input  logic align_pulse,
  input  logic slow_en,
  input  logic test_mode,
  input  logic div_bypass,
  output logic aligned,
  output logic ready
);
  seq_state_t state_q, state_d;
  logic       aligned_q, aligned_d;
  logic       ready_q, ready_d;
  logic       straps_ok;

  assign straps_ok = !test_mode && !div_bypass;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOCK:  if (pll_lock)    state_d = ST_ALIGN;
      ST_ALIGN: if (align_pulse) state_d = ST_SPIN;
      ST_SPIN:  if (slow_en)     state_d = ST_DONE;
      ST_DONE:                   state_d = ST_DONE;
      default:                   state_d = ST_LOCK;
    endcase
    aligned_d = (state_d == ST_SPIN) || (state_d == ST_DONE);
    ready_d   = (state_d == ST_DONE) && pll_lock && straps_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LOCK;
      aligned_q <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      aligned_q <= aligned_d;
      ready_q   <= ready_d;
    end
  end

  assign aligned = aligned_q;
  assign ready   = ready_q;
endmodule

// File: rtl/clkgen_cfg_reg.sv
module clkgen_cfg_reg #(
  parameter int          W       = 16,
  parameter logic [W-1:0] DEFAULT = '0,
  parameter logic [W-1:0] KEEP    = '0
) (
  input  logic         clk,
  input  logic         cold_rst_n,
  input  logic         warm_rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] keep_q, keep_d;
  logic [W-1:0] soft_q, soft_d;

  always_comb begin
    keep_d = keep_q;
    soft_d = soft_q;
    if (wr_en) begin
      keep_d = wr_data & KEEP;
      soft_d = wr_data & ~KEEP;
    end
  end

  // clock-programming fields: cleared only by cold reset
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) keep_q <= DEFAULT & KEEP;
    else             keep_q <= keep_d;
  end

  // remaining fields: cleared by warm or cold reset
  always_ff @(posedge clk or negedge warm_rst_n) begin
    if (!warm_rst_n) soft_q <= DEFAULT & ~KEEP;
    else             soft_q <= soft_d;
  end

  assign q = (keep_q & KEEP) | (soft_q & ~KEEP);
endmodule

// File: rtl/clkgen_rst_seq.sv
module clkgen_rst_seq #(
  parameter int           CFG_W       = 16,
  parameter logic [15:0]  CFG_DEFAULT = 16'h5A3C,
  parameter logic [15:0]  CFG_KEEP    = 16'h00FF,
  parameter int           SYNC_STAGES = 2,
  parameter int           FAST_DIV    = 2,
  parameter int           SLOW_DIV    = 4
) (
  input  logic             clk,
  input  logic             pll_rst_n,
  input  logic             logic_rst_n,
  input  logic             pll_lock,
  input  logic             align_pulse,
  input  logic             test_mode,
  input  logic             div_bypass,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             pll_rst_out_n,
  output logic             gclk_rst_n,
  output logic             aligned_rst_n,
  output logic             io2x_en,
  output logic             io_en,
  output logic             ready,
  output logic [CFG_W-1:0] cfg_q
);
  localparam logic [CFG_W-1:0] DEF_W  = CFG_W'(CFG_DEFAULT);
  localparam logic [CFG_W-1:0] KEEP_W = CFG_W'(CFG_KEEP);

  logic both_rst_n;
  logic pll_sync;
  logic glob_sync;
  logic aligned;
  logic fast_en;
  logic slow_en;

  assign both_rst_n = pll_rst_n & logic_rst_n;

  clkgen_rst_sync #(.STAGES(SYNC_STAGES)) u_pll_sync (
    .clk    (clk),
    .arst_n (pll_rst_n),
    .d      (1'b1),
    .q      (pll_sync)
  );

  // global reset chain is fed from the PLL chain: enforces release order
  clkgen_rst_sync #(.STAGES(SYNC_STAGES)) u_glob_sync (
    .clk    (clk),
    .arst_n (both_rst_n),
    .d      (pll_sync),
    .q      (glob_sync)
  );

  clkgen_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (glob_sync),
    .pll_lock    (pll_lock),
    .align_pulse (align_pulse),
    .slow_en     (slow_en),
    .test_mode   (test_mode),
    .div_bypass  (div_bypass),
    .aligned     (aligned),
    .ready       (ready)
  );

  clkgen_en_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_en (
    .clk     (clk),
    .rst_n   (glob_sync),
    .aligned (aligned),
    .fast_en (fast_en),
    .slow_en (slow_en)
  );

  clkgen_cfg_reg #(.W(CFG_W), .DEFAULT(DEF_W), .KEEP(KEEP_W)) u_cfg (
    .clk        (clk),
    .cold_rst_n (pll_rst_n),
    .warm_rst_n (both_rst_n),
    .wr_en      (cfg_we & glob_sync),
    .wr_data    (cfg_wdata),
    .q          (cfg_q)
  );

  assign pll_rst_out_n = pll_sync;
  assign gclk_rst_n    = glob_sync;
  assign aligned_rst_n = aligned;
  assign io2x_en       = fast_en;
  assign io_en         = slow_en;
endmodule

// File: rtl/clkgen_rst_seq_chk.sv
module clkgen_rst_seq_chk (
  input logic clk,
  input logic logic_rst_n,
  input logic align_pulse,
  input logic test_mode,
  input logic div_bypass,
  input logic pll_rst_out_n,
  input logic gclk_rst_n,
  input logic aligned_rst_n,
  input logic io2x_en,
  input logic io_en,
  input logic ready
);
  assert_rst_order_R2: assert property (@(posedge clk) disable iff (!logic_rst_n)
    !pll_rst_out_n |-> !gclk_rst_n);

  assert_align_cause_R4: assert property (@(posedge clk) disable iff (!gclk_rst_n)
    $rose(aligned_rst_n) |-> $past(align_pulse));

  assert_fast_single_R5: assert property (@(posedge clk) disable iff (!gclk_rst_n)
    io2x_en |=> !io2x_en);

  assert_fast_gated_R5: assert property (@(posedge clk) disable iff (!gclk_rst_n)
    io2x_en |-> aligned_rst_n);

  assert_slow_on_fast_R6: assert property (@(posedge clk) disable iff (!gclk_rst_n)
    io_en |-> io2x_en);

  assert_ready_aligned_R7: assert property (@(posedge clk) disable iff (!gclk_rst_n)
    ready |-> aligned_rst_n);

  assert_strap_block_R8: assert property (@(posedge clk) disable iff (!gclk_rst_n)
    (test_mode || div_bypass) |=> !ready);
endmodule

bind clkgen_rst_seq clkgen_rst_seq_chk u_chk (.*);

// File: tb/tb_clkgen_rst_seq.sv
module tb_clkgen_rst_seq;
  localparam logic [15:0] DEF  = 16'h5A3C;
  localparam logic [15:0] KEEP = 16'h00FF;

  logic clk = 1'b0;
  logic pll_rst_n, logic_rst_n, pll_lock, align_pulse, test_mode, div_bypass, cfg_we;
  logic [15:0] cfg_wdata;
  logic pll_rst_out_n, gclk_rst_n, aligned_rst_n, io2x_en, io_en, ready;
  logic [15:0] cfg_q;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clkgen_rst_seq dut (
    .clk(clk), .pll_rst_n(pll_rst_n), .logic_rst_n(logic_rst_n), .pll_lock(pll_lock),
    .align_pulse(align_pulse), .test_mode(test_mode), .div_bypass(div_bypass),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pll_rst_out_n(pll_rst_out_n),
    .gclk_rst_n(gclk_rst_n), .aligned_rst_n(aligned_rst_n), .io2x_en(io2x_en),
    .io_en(io_en), .ready(ready), .cfg_q(cfg_q)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference model, updated on every rising edge
  int  pcnt = 0, gcnt = 0, mode = 0, cyc = 0;
  bit  m_pll = 0, m_gclk = 0, m_al = 0, m_fast = 0, m_slow = 0, m_rdy = 0;
  logic [15:0] m_cfg = DEF;

  always @(posedge clk) begin
    bit old_pll, old_gclk, nf, ns;
    old_pll  = m_pll;
    old_gclk = m_gclk;
    if (!pll_rst_n) pcnt = 0; else if (pcnt < 2) pcnt++;
    if (!(pll_rst_n && logic_rst_n)) gcnt = 0;
    else if (old_pll && gcnt < 2) gcnt++;
    m_pll  = (pcnt >= 2);
    m_gclk = (gcnt >= 2);
    if (!pll_rst_n) m_cfg = DEF;
    else if (!logic_rst_n) m_cfg = (m_cfg & KEEP) | (DEF & ~KEEP);
    else if (cfg_we && old_gclk) m_cfg = cfg_wdata;
    if (!(pll_rst_n && logic_rst_n) || !old_gclk) begin
      mode = 0; cyc = 0; m_al = 0; m_fast = 0; m_slow = 0; m_rdy = 0;
    end else begin
      nf = m_al && (cyc % 2 == 1);
      ns = m_al && (cyc % 4 == 3);
      case (mode)
        0: if (pll_lock) mode = 1;
        1: if (align_pulse) begin mode = 2; cyc = 0; m_al = 1; end
        default: cyc++;
      endcase
      m_fast = nf;
      m_slow = ns;
      m_rdy  = (mode == 2) && (cyc >= 5) && pll_lock && !test_mode && !div_bypass;
    end
    #1;
    if (!finished) begin
      check("R1 pll_rst_out_n", 16'(pll_rst_out_n), 16'(m_pll));
      check("R3 gclk_rst_n",    16'(gclk_rst_n),    16'(m_gclk));
      check("R4 aligned_rst_n", 16'(aligned_rst_n), 16'(m_al));
      check("R5 io2x_en",       16'(io2x_en),       16'(m_fast));
      check("R6 io_en",         16'(io_en),         16'(m_slow));
      check("R7 ready",         16'(ready),         16'(m_rdy));
      check("R9 cfg_q",         cfg_q,              m_cfg);
    end
  end

  initial begin
    #(4 * 50000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n2, n4;
    pll_rst_n = 0; logic_rst_n = 0; pll_lock = 0; align_pulse = 0;
    test_mode = 0; div_bypass = 0; cfg_we = 0; cfg_wdata = '0;
    step(3);
    check("R9 cold default", cfg_q, DEF);
    check("R7 reset ready", 16'(ready), 16'h0);

    logic_rst_n = 1;
    step(5);
    check("R2 logic first ignored", 16'(gclk_rst_n), 16'h0);
    pll_rst_n = 1;
    step(6);
    check("R1 pll released", 16'(pll_rst_out_n), 16'h1);
    check("R3 gclk released", 16'(gclk_rst_n), 16'h1);

    align_pulse = 1; step(1); align_pulse = 0;
    step(3);
    check("R4 early align ignored", 16'(aligned_rst_n), 16'h0);

    cfg_we = 1; cfg_wdata = 16'h1234; step(1); cfg_we = 0;
    pll_lock = 1; step(3);
    align_pulse = 1; step(1); align_pulse = 0;
    check("R4 aligned rises", 16'(aligned_rst_n), 16'h1);
    step(12);
    check("R7 ready up", 16'(ready), 16'h1);
    check("R10 write accepted", cfg_q, 16'h1234);
    n2 = 0; n4 = 0;
    for (int i = 0; i < 16; i++) begin
      step(1);
      n2 += int'(io2x_en);
      n4 += int'(io_en);
    end
    check("R5 io2x rate", 16'(n2), 16'd8);
    check("R6 io rate", 16'(n4), 16'd4);

    test_mode = 1; step(2);
    check("R8 test_mode blocks ready", 16'(ready), 16'h0);
    test_mode = 0; step(2);
    check("R8 ready back", 16'(ready), 16'h1);
    div_bypass = 1; step(2);
    check("R8 bypass blocks ready", 16'(ready), 16'h0);
    div_bypass = 0; step(2);

    logic_rst_n = 0; #1;
    check("R11 ready drops", 16'(ready), 16'h0);
    check("R11 aligned drops", 16'(aligned_rst_n), 16'h0);
    cfg_we = 1; cfg_wdata = 16'hFFFF;
    step(2);
    cfg_we = 0;
    check("R9 warm keeps clock byte", cfg_q, 16'h5A34);
    check("R10 write in reset ignored", cfg_q, 16'h5A34);
    logic_rst_n = 1;
    step(5);
    check("R11 restart waits align", 16'(aligned_rst_n), 16'h0);
    align_pulse = 1; step(1); align_pulse = 0;
    step(10);
    check("R11 ready after restart", 16'(ready), 16'h1);

    pll_rst_n = 0; step(2);
    check("R9 cold reset default", cfg_q, DEF);
    check("R11 cold drops ready", 16'(ready), 16'h0);
    pll_rst_n = 1; step(8);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule